// File: doc/BRIEF.md
# Flash Write Status Bit Generator

This block builds the byte that a flash device returns on reads while an embedded program or erase runs, or while an erase is suspended. The command sequencer tells it which operation is active, the byte being programmed, which sectors are being erased, and whether the erase timer window has closed. A busy timer supplies a timeout flag. The bus supplies a read strobe with active-low chip and output enables, plus the read address.

From these inputs the block keeps two independent toggle bits. The first flips on every qualified read during program or erase. The second flips only on qualified reads aimed at a sector marked for erase. Alongside them it produces a data-polling bit, a sticky timeout bit, an erase-window bit and a ready/busy line. Host software polls the status byte to tell three cases apart: still running, finished, or failed. It can also tell whether a given sector is erasing or suspended.

Top module: `flash_status_gen`

## Requirements
- R1: While the operation code is program (2'b01), bit 7 of the status reads as the inverse of bit 7 of the target data.
- R2: While the operation code is erase (2'b10) or suspend (2'b11), bit 7 reads 0. While idle (2'b00), bit 7 equals bit 7 of the last byte seen during program, and bits 6..0 read 0.
- R3: A qualified read is a clock edge with the strobe high and both enables low. During program or erase, bit 6 inverts after each qualified read, whatever the read address. Strobes with either enable high do not count.
- R4: In suspend, bit 6 holds its value across reads. On entering idle, the toggle state clears to 0.
- R5: During erase or suspend, bit 2 inverts after each qualified read whose sector has its mask bit set. The sector is the top SECT_W bits of the read address, and mask bit i stands for sector i. Reads of other sectors leave bit 2 unchanged. Outside erase and suspend, bit 2 reads 0.
- R6: If the timeout input is high at an edge during program or erase, bit 5 reads 1 from the next cycle onward. It stays set through later cycles until the operation returns to idle, which clears it.
- R7: During erase or suspend, bit 3 follows the window-closed input. In every other state it reads 0.
- R8: The ready line is low during program and erase, and high in idle and suspend.
- R9: Bits 0, 1 and 4 always read 0.
- R10: After reset the status reads 0x00 and the ready line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 2 | Operation: 0 idle, 1 program, 2 erase, 3 suspend |
| tgt_data_i | input | 8 | Byte being programmed |
| erase_mask_i | input | 2**SECT_W | One bit per sector marked for erase |
| win_closed_i | input | 1 | Erase timer window has closed |
| timeout_i | input | 1 | Busy timer limit exceeded |
| rd_stb_i | input | 1 | Read strobe |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| rd_addr_i | input | ADDR_W | Read address |
| status_o | output | 8 | Status byte |
| rdy_o | output | 1 | Ready (1) / busy (0) |

## Verification
The hardest situation to reach is telling a sector that is suspended apart from one that is actively erasing. This needs bit 6 frozen while bit 2 still flips on one sector and stays still on another. The stimulus table reaches it by stepping from erase into suspend with the same mask, then reading a marked sector and an unmarked one. Each step compares the status before and after one strobe. The sticky timeout is reached by a single timeout pulse. The bench then watches that the bit survives the pulse, and checks that it has cleared after an idle cycle and a new program.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [1:0] {
        FSG_IDLE  = 2'b00,
        FSG_PROG  = 2'b01,
        FSG_ERASE = 2'b10,
        FSG_SUSP  = 2'b11
    } fsg_op_e;

    function automatic logic fsg_busy(input fsg_op_e op);
        return (op == FSG_PROG) || (op == FSG_ERASE);
    endfunction

    function automatic logic fsg_erase_ctx(input fsg_op_e op);
        return (op == FSG_ERASE) || (op == FSG_SUSP);
    endfunction

endpackage

// File: rtl/fsg_sector_hit.sv
module fsg_sector_hit #(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 3
) (
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [(1<<SECT_W)-1:0] mask_i,
    output logic                   hit_o
);
    localparam int NSECT = 1 << SECT_W;

    logic [SECT_W-1:0] sect;
    logic [NSECT-1:0]  match;

    assign sect = addr_i[ADDR_W-1 -: SECT_W];

    for (genvar i = 0; i < NSECT; i++) begin : g_sect
        assign match[i] = mask_i[i] && (sect == SECT_W'(i));
    end

    assign hit_o = |match;
endmodule

// File: rtl/fsg_toggle_pair.sv
module fsg_toggle_pair
    import fsg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  fsg_op_e op_i,
    input  logic    rd_i,
    input  logic    hit_i,
    output logic    any_tog_o,
    output logic    sect_tog_o
);
    typedef struct packed {
        logic any_tog;
        logic sect_tog;
    } tog_t;

    tog_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (op_i == FSG_IDLE) begin
            st_d.any_tog  = 1'b0;
            st_d.sect_tog = 1'b0;
        end else if (rd_i) begin
            if (fsg_busy(op_i))
                st_d.any_tog = ~st_q.any_tog;
            if (fsg_erase_ctx(op_i) && hit_i)
                st_d.sect_tog = ~st_q.sect_tog;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign any_tog_o  = st_q.any_tog;
    assign sect_tog_o = st_q.sect_tog;

    p_any_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && fsg_busy(op_i)) |=> (any_tog_o != $past(any_tog_o)));

    p_any_hold_susp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == FSG_SUSP) |=> (any_tog_o == $past(any_tog_o)));

    p_sect_hold_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != FSG_IDLE && !(rd_i && hit_i)) |=> (sect_tog_o == $past(sect_tog_o)));
endmodule

// File: rtl/fsg_fault_latch.sv
module fsg_fault_latch
    import fsg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  fsg_op_e op_i,
    input  logic    timeout_i,
    output logic    fault_o
);
    logic fault_d, fault_q;

    always_comb begin
        fault_d = fault_q;
        if (op_i == FSG_IDLE)
            fault_d = 1'b0;
        else if (fsg_busy(op_i) && timeout_i)
            fault_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= fault_d;
    end

    assign fault_o = fault_q;

    p_fault_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && op_i != FSG_IDLE) |=> fault_o);

    p_fault_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == FSG_IDLE) |=> !fault_o);
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import fsg_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             op_i,
    input  logic [7:0]             tgt_data_i,
    input  logic [(1<<SECT_W)-1:0] erase_mask_i,
    input  logic                   win_closed_i,
    input  logic                   timeout_i,
    input  logic                   rd_stb_i,
    input  logic                   ce_n_i,
    input  logic                   oe_n_i,
    input  logic [ADDR_W-1:0]      rd_addr_i,
    output logic [7:0]             status_o,
    output logic                   rdy_o
);
    localparam int NSECT = 1 << SECT_W;

    typedef struct packed {
        logic last_msb;
    } top_st_t;

    fsg_op_e op;
    logic    rd_ok, hit, any_tog, sect_tog, fault;
    top_st_t st_d, st_q;

    assign op    = fsg_op_e'(op_i);
    assign rd_ok = rd_stb_i && !ce_n_i && !oe_n_i;

    fsg_sector_hit #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_hit (
        .addr_i (rd_addr_i),
        .mask_i (erase_mask_i[NSECT-1:0]),
        .hit_o  (hit)
    );

    fsg_toggle_pair u_tog (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op),
        .rd_i       (rd_ok),
        .hit_i      (hit),
        .any_tog_o  (any_tog),
        .sect_tog_o (sect_tog)
    );

    fsg_fault_latch u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .timeout_i (timeout_i),
        .fault_o   (fault)
    );

    always_comb begin
        st_d = st_q;
        if (op == FSG_PROG)
            st_d.last_msb = tgt_data_i[7];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status_o = 8'h00;
        unique case (op)
            FSG_IDLE:  status_o[7] = st_q.last_msb;
            FSG_PROG:  begin
                status_o[7] = ~tgt_data_i[7];
                status_o[6] = any_tog;
                status_o[5] = fault;
            end
            FSG_ERASE, FSG_SUSP: begin
                status_o[6] = any_tog;
                status_o[5] = fault;
                status_o[3] = win_closed_i;
                status_o[2] = sect_tog;
            end
            default: status_o = 8'h00;
        endcase
        rdy_o = !fsg_busy(op);
    end

    p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[4] == 1'b0) && (status_o[1:0] == 2'b00));

    p_susp_b6_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == FSG_SUSP) |=> (op != FSG_SUSP) || (status_o[6] == $past(status_o[6])));

    p_idle_after_prog_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == FSG_PROG) |=> (op != FSG_IDLE) || (status_o == {$past(tgt_data_i[7]), 7'b0}));

    p_no_rd_no_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_ok && op == FSG_ERASE) |=> (op != FSG_ERASE) || $stable(status_o[6]));
endmodule

// File: tb/tb_flash_status_gen.sv
module tb_flash_status_gen;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 19;
    localparam int SECT_W = 3;
    localparam int NSECT = 1 << SECT_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        op = 2'b00;
    logic [7:0]        tgt_data = 8'h00;
    logic [NSECT-1:0]  mask = '0;
    logic              win = 1'b0;
    logic              timeout = 1'b0;
    logic              stb = 1'b0;
    logic              ce_n = 1'b1;
    logic              oe_n = 1'b1;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        status;
    logic              rdy;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_status_gen #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .tgt_data_i(tgt_data),
        .erase_mask_i(mask), .win_closed_i(win), .timeout_i(timeout),
        .rd_stb_i(stb), .ce_n_i(ce_n), .oe_n_i(oe_n), .rd_addr_i(rd_addr),
        .status_o(status), .rdy_o(rdy)
    );

    typedef struct packed {
        logic [1:0] op;
        logic [7:0] data;
        logic [7:0] mask;
        logic [2:0] sect;
        logic       win;
        logic       stb;
        logic       e7;
        logic       f6;
        logic       f2;
        logic       e3;
        logic       erdy;
    } vec_t;

    localparam vec_t TBL [10] = '{
        '{2'd1, 8'h80, 8'h00, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{2'd1, 8'h00, 8'h00, 3'd6, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{2'd1, 8'h7f, 8'h00, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{2'd2, 8'hff, 8'h04, 3'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{2'd2, 8'hff, 8'h04, 3'd5, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        '{2'd3, 8'h00, 8'h04, 3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        '{2'd3, 8'h00, 8'h04, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{2'd2, 8'h00, 8'h81, 3'd7, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{2'd2, 8'h00, 8'h81, 3'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        '{2'd2, 8'h00, 8'h81, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_read(input logic cen, input logic oen);
        @(negedge clk);
        stb = 1'b1; ce_n = cen; oe_n = oen;
        @(negedge clk);
        stb = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
        #1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] s0;
        repeat (3) @(negedge clk);
        #1;
        chk("R10 status after reset", status, 8'h00);
        chk("R10 ready after reset", rdy, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            op = TBL[i].op; tgt_data = TBL[i].data; mask = TBL[i].mask;
            win = TBL[i].win;
            rd_addr = {TBL[i].sect, 16'(i * 4099)};
            #1;
            s0 = status;
            if (TBL[i].stb) pulse_read(1'b0, 1'b0);
            else begin @(negedge clk); #1; end
            chk("R1/R2 bit7", status[7], TBL[i].e7);
            chk("R3/R4 bit6 flip", status[6] ^ s0[6], TBL[i].f6);
            chk("R5 bit2 flip", status[2] ^ s0[2], TBL[i].f2);
            if (TBL[i].op == 2'd1) chk("R5 bit2 zero in program", status[2], 1'b0);
            chk("R7 bit3", status[3], TBL[i].e3);
            chk("R8 ready", rdy, TBL[i].erdy);
            chk("R9 unused bits", {status[4], status[1:0]}, 3'b000);
        end

        @(negedge clk);
        op = 2'd2; mask = 8'h01; rd_addr = '0; #1;
        s0 = status;
        pulse_read(1'b1, 1'b0);
        chk("R3 ce_n high ignored bit6", status[6], s0[6]);
        chk("R5 ce_n high ignored bit2", status[2], s0[2]);
        pulse_read(1'b0, 1'b1);
        chk("R3 oe_n high ignored bit6", status[6], s0[6]);
        chk("R5 oe_n high ignored bit2", status[2], s0[2]);

        @(negedge clk);
        op = 2'd1; tgt_data = 8'h80; timeout = 1'b1; #1;
        chk("R6 timeout not yet visible", status[5], 1'b0);
        @(negedge clk);
        timeout = 1'b0; #1;
        chk("R6 timeout set", status[5], 1'b1);
        repeat (3) @(negedge clk);
        #1;
        chk("R6 timeout sticky", status[5], 1'b1);
        @(negedge clk);
        op = 2'd3; #1;
        chk("R6 timeout kept in suspend", status[5], 1'b1);
        chk("R2 bit7 zero in suspend", status[7], 1'b0);

        @(negedge clk);
        op = 2'd1; tgt_data = 8'h80;
        @(negedge clk);
        op = 2'd0; tgt_data = 8'h00; #1;
        chk("R2 idle shows last programmed msb", status, 8'h80);
        chk("R8 ready in idle", rdy, 1'b1);
        @(negedge clk);
        op = 2'd1; tgt_data = 8'hff; #1;
        chk("R6 timeout cleared by idle", status[5], 1'b0);
        chk("R4 toggle cleared by idle", status[6], 1'b0);
        chk("R1 complement of data msb", status[7], 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule